// File: doc/BRIEF.md
# Eight-LED Looping Light Show Sequencer

The block steps a row of eight LEDs through a fixed light show that repeats forever. One pass consists of a single lit LED running up the row, the same LED running back down, a curtain that opens from the middle pair outward, the curtain closing again, four toggles of an interleaved odd/even pattern and four toggles of an upper-half/lower-half pattern. The next pass then starts with the running light at the bottom of the row.

A free-running timer derived from the system clock paces the show. One select input sets the step interval to one second or to two seconds. A new setting is sampled only when a step completes, so a step already in progress keeps the interval it started with. The clock rate is a parameter (50 MHz by default), so the timer counts `CLK_HZ` or `2*CLK_HZ` cycles per step.

Top module: `led_show_seq`

## Requirements
- R1: While `rst` is high at a clock edge, `led` becomes 8'b00000001 and the step timer clears. After release, the first step takes place on exactly the `CLK_HZ`-th (slow: `2*CLK_HZ`-th) rising edge.
- R2: Steps 0 to 7 of a pass light only `led[k]` at step k, so one lit LED moves from bit 0 to bit 7.
- R3: Steps 8 to 15 light only `led[15-k]`, so one lit LED moves from bit 7 back to bit 0.
- R4: Steps 16 to 19 open the curtain: 8'h18, 8'h3C, 8'h7E, 8'hFF.
- R5: Steps 20 to 23 close the curtain: 8'h7E, 8'h3C, 8'h18, 8'h00.
- R6: Steps 24 to 27 toggle the interleaved pattern: 8'hAA, 8'h55, 8'hAA, 8'h55.
- R7: Steps 28 to 31 toggle the halves: 8'hF0, 8'h0F, 8'hF0, 8'h0F. The step after step 31 is step 0 (8'h01).
- R8: With `slow_sel`=0, `led` holds for exactly `CLK_HZ` cycles between changes. With `slow_sel`=1, it holds for exactly `2*CLK_HZ` cycles.
- R9: A value of `slow_sel` sampled at a step edge sets the length of the step that follows. Changes between step edges have no effect on the step in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (`CLK_HZ` cycles per second) |
| rst | input | 1 | Synchronous active-high reset |
| slow_sel | input | 1 | Step interval select: 0 = one second, 1 = two seconds |
| led | output | 8 | LED drive, bit 0 is the bottom of the row |

## Verification
Two functions can land on the same clock edge: a step boundary and a change of the interval select. A synchronous reset can also coincide with a boundary. The bench drives `slow_sel` and `rst` to new random values at random points, and many of those points fall on or next to a boundary edge. A bench model samples the select only at step edges and predicts the LED value on every cycle. A step that follows a mid-step select change is reported as the interval-rule check. A wrong step length or a lost reset shows up as a pattern mismatch on the exact cycle.

// File: rtl/led_show_pkg.sv
package led_show_pkg;

    typedef enum logic [2:0] {
        PH_LEFT,
        PH_RIGHT,
        PH_OPEN,
        PH_CLOSE,
        PH_ALT,
        PH_HALF
    } phase_e;

    typedef struct packed {
        phase_e     phase;
        logic [7:0] idx;
    } seq_state_t;

    // Number of steps a phase lasts for a row of w LEDs.
    function automatic logic [7:0] phase_len(phase_e p, int w, int blinks);
        case (p)
            PH_LEFT, PH_RIGHT: return 8'(w);
            PH_OPEN, PH_CLOSE: return 8'(w / 2);
            default:           return 8'(blinks);
        endcase
    endfunction

    function automatic phase_e phase_next(phase_e p);
        case (p)
            PH_LEFT:  return PH_RIGHT;
            PH_RIGHT: return PH_OPEN;
            PH_OPEN:  return PH_CLOSE;
            PH_CLOSE: return PH_ALT;
            PH_ALT:   return PH_HALF;
            default:  return PH_LEFT;
        endcase
    endfunction

    // LED image for step k of phase p; bits at w and above stay zero.
    function automatic logic [31:0] show_pattern(phase_e p, logic [7:0] k, int w);
        logic [31:0] v;
        int          h;
        int          kk;
        logic        odd_k;
        v     = '0;
        h     = w / 2;
        kk    = int'(k);
        odd_k = k[0];
        for (int i = 0; i < 32; i++) begin
            if (i < w) begin
                case (p)
                    PH_LEFT:  v[i] = (i == kk);
                    PH_RIGHT: v[i] = (i == w - 1 - kk);
                    PH_OPEN:  v[i] = (i >= h - 1 - kk) && (i <= h + kk);
                    PH_CLOSE: v[i] = (kk < h - 1) && (i >= kk + 1) && (i <= w - 2 - kk);
                    PH_ALT:   v[i] = ((i % 2) == 1) != odd_k;
                    PH_HALF:  v[i] = (i >= h) != odd_k;
                    default:  v[i] = 1'b0;
                endcase
            end
        end
        return v;
    endfunction

endpackage

// File: rtl/led_step_timer.sv
module led_step_timer #(
    parameter int unsigned TICKS = 50_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic slow_sel,
    output logic step
);
    localparam int unsigned CNT_W = $clog2(2 * TICKS);
    localparam logic [CNT_W-1:0] LIM_FAST = CNT_W'(TICKS - 1);
    localparam logic [CNT_W-1:0] LIM_SLOW = CNT_W'(2 * TICKS - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             slow_q;

    assign step = (cnt_q == (slow_q ? LIM_SLOW : LIM_FAST));

    always_ff @(posedge clk) begin
        if (rst || step) begin
            cnt_q  <= '0;
            slow_q <= slow_sel;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    // R9: the interval setting only moves on a step edge
    a_r9_speed_hold: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(slow_q));

    // R8: two steps are never back to back
    a_r8_step_isolated: assert property (@(posedge clk) disable iff (rst)
        step |=> !step);

endmodule

// File: rtl/led_phase_seq.sv
module led_phase_seq
    import led_show_pkg::*;
#(
    parameter int LED_W  = 8,
    parameter int BLINKS = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       step,
    output seq_state_t st
);
    localparam logic [7:0] LAST_BLINK = 8'(BLINKS - 1);

    seq_state_t st_q;
    logic [7:0] last_idx;

    assign last_idx = phase_len(st_q.phase, LED_W, BLINKS) - 8'd1;
    assign st       = st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.phase <= PH_LEFT;
            st_q.idx   <= '0;
        end else if (step) begin
            if (st_q.idx == last_idx) begin
                st_q.phase <= phase_next(st_q.phase);
                st_q.idx   <= '0;
            end else begin
                st_q.idx   <= st_q.idx + 8'd1;
            end
        end
    end

    // R8: state holds between steps
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !step |=> ($stable(st_q.phase) && $stable(st_q.idx)));

    // R7: the last half-blink step wraps to the first running step
    a_r7_wrap: assert property (@(posedge clk) disable iff (rst)
        (step && st_q.phase == PH_HALF && st_q.idx == LAST_BLINK)
        |=> (st_q.phase == PH_LEFT && st_q.idx == 8'd0));

endmodule

// File: rtl/led_pattern_map.sv
module led_pattern_map
    import led_show_pkg::*;
#(
    parameter int LED_W = 8
) (
    input  seq_state_t       st,
    output logic [LED_W-1:0] led
);
    logic [31:0] img;

    assign img = show_pattern(st.phase, st.idx, LED_W);
    assign led = img[LED_W-1:0];

endmodule

// File: rtl/led_show_seq.sv
module led_show_seq
    import led_show_pkg::*;
#(
    parameter int unsigned CLK_HZ = 50_000_000,
    parameter int          LED_W  = 8,
    parameter int          BLINKS = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             slow_sel,
    output logic [LED_W-1:0] led
);
    logic       step;
    seq_state_t st;

    led_step_timer #(.TICKS(CLK_HZ)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .slow_sel (slow_sel),
        .step     (step)
    );

    led_phase_seq #(.LED_W(LED_W), .BLINKS(BLINKS)) u_seq (
        .clk  (clk),
        .rst  (rst),
        .step (step),
        .st   (st)
    );

    led_pattern_map #(.LED_W(LED_W)) u_map (
        .st  (st),
        .led (led)
    );

    // R2, R3: exactly one LED lit while running
    a_r2_single_lit: assert property (@(posedge clk) disable iff (rst)
        (st.phase == PH_LEFT || st.phase == PH_RIGHT) |-> ($countones(led) == 1));

    // R6: interleaved blink lights half the row
    a_r6_half_lit: assert property (@(posedge clk) disable iff (rst)
        (st.phase == PH_ALT || st.phase == PH_HALF) |-> ($countones(led) == LED_W / 2));

    // R1: reset returns the row to the bottom LED
    a_r1_reset_led: assert property (@(posedge clk)
        rst |=> (led == LED_W'(1)));

endmodule

// File: tb/led_show_seq_bench.sv
module led_show_seq_bench;
    localparam int T = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       slow_sel = 1'b0;
    logic [7:0] led;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    bit    chk_en = 1'b0;

    int    m_cnt = 0;
    int    m_step = 0;
    bit    m_slow = 1'b0;
    bit    m_fresh = 1'b1;
    bit    m_chg = 1'b0;
    string cur_lbl = "R1";

    led_show_seq #(.CLK_HZ(T)) u_led_show_seq (
        .clk      (clk),
        .rst      (rst),
        .slow_sel (slow_sel),
        .led      (led)
    );

    always #4 clk = ~clk;

    function automatic logic [7:0] exp_led(int s);
        case (s)
            16: return 8'h18;  17: return 8'h3C;  18: return 8'h7E;  19: return 8'hFF;
            20: return 8'h7E;  21: return 8'h3C;  22: return 8'h18;  23: return 8'h00;
            24: return 8'hAA;  25: return 8'h55;  26: return 8'hAA;  27: return 8'h55;
            28: return 8'hF0;  29: return 8'h0F;  30: return 8'hF0;  31: return 8'h0F;
            default: begin
                if (s < 8) return 8'h01 << s;
                return 8'h80 >> (s - 8);
            end
        endcase
    endfunction

    function automatic string phase_lbl(int s);
        if (s < 8)  return "R2";
        if (s < 16) return "R3";
        if (s < 20) return "R4";
        if (s < 24) return "R5";
        if (s < 28) return "R6";
        return "R7";
    endfunction

    // Bench model of the show, built from the requirements
    always @(posedge clk) begin
        int period;
        if (rst) begin
            m_cnt   = 0;
            m_step  = 0;
            m_slow  = slow_sel;
            m_fresh = 1'b1;
            m_chg   = 1'b0;
            cur_lbl = "R1";
        end else begin
            period = m_slow ? 2 * T : T;
            if (slow_sel != m_slow) m_chg = 1'b1;
            if (m_cnt == period - 1) begin
                m_cnt  = 0;
                m_step = (m_step + 1) % 32;
                m_slow = slow_sel;
                if (m_fresh)     cur_lbl = "R1";
                else if (m_chg)  cur_lbl = "R9";
                else             cur_lbl = (m_step == 0) ? "R7" : phase_lbl(m_step);
                m_fresh = 1'b0;
                m_chg   = 1'b0;
            end else begin
                m_cnt   = m_cnt + 1;
                cur_lbl = "R8";
            end
        end
    end

    always @(negedge clk) begin
        if (chk_en && !done) begin
            checks++;
            if (led !== exp_led(m_step)) begin
                errors++;
                $display("FAIL %s: step %0d led=%b expected=%b", cur_lbl, m_step, led, exp_led(m_step));
            end
        end
    end

    task automatic run_cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int unsigned seed;
        seed = 32'd4711;
        void'($urandom(seed));
        run_cycles(3);
        checks++;
        if (led !== 8'h01) begin
            errors++;
            $display("FAIL R1: reset led=%b expected=%b", led, 8'h01);
        end
        chk_en = 1'b1;
        rst = 1'b0;
        // R2..R7, R8: a full pass at the fast interval, then one at the slow one
        run_cycles(32 * T + 5);
        slow_sel = 1'b1;
        run_cycles(64 * T + 7);
        // R9: change in the middle of a step, then flip back before the edge
        slow_sel = 1'b0;
        run_cycles(3);
        slow_sel = 1'b1;
        run_cycles(5 * T);
        // R1: reset part way through a pass
        rst = 1'b1;
        run_cycles(2);
        rst = 1'b0;
        run_cycles(4 * T);
        // Random mix of interval changes and resets
        for (int it = 0; it < 700; it++) begin
            slow_sel = 1'($urandom_range(0, 1));
            if ($urandom_range(0, 19) == 0) begin
                rst = 1'b1;
                run_cycles(1 + $urandom_range(0, 2));
                rst = 1'b0;
            end
            run_cycles(1 + $urandom_range(0, 3 * T));
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not end, actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule